// File: doc/BRIEF.md
# Fetch Address Watchpoint Comparator

This block watches the instruction fetch address stream of a processor core and flags fetches that hit one of four programmable word addresses. The four compare registers are grouped into two pairs (first/second and third/fourth). Each pair can run as two independent exact compares. It can also be joined into one address range, either inside the range or outside it. When range auto-toggle is enabled, the pair swaps between inside and outside sense after every range hit. Each compare is qualified by the privilege level of the fetch and by the instruction translation-space bit. The two pairs share one control word.

The fetch side is an observation-only stream. It is a valid strobe with an address and two qualifier bits. There is no ready signal, because the watcher never applies back-pressure: every beat with `fetch_valid` high is evaluated in the cycle it is presented. Beats with `fetch_valid` low carry no meaning and are ignored. The per-compare hit flags are combinational from the current beat and the stored configuration. A registered debug event pulse follows one cycle after any hit. The configuration port is a plain write strobe with a select, and a combinational read of the selected register.

Top module: `fwatch_top`

## Requirements
- R1: Privilege qualifier per compare (2 bits): 00 passes any fetch, 10 passes only when `fetch_user`=0, 11 passes only when `fetch_user`=1.
- R2: Translation qualifier per compare (2 bits): 00 ignores `fetch_ispace`, 10 passes only when it is 0, 11 passes only when it is 1.
- R3: In exact mode (pair mode 00) each compare of the pair hits independently when `fetch_addr[31:2]` equals its register bits [31:2]; address bits [1:0] are ignored.
- R4: Inside-range mode (pair mode 10) hits when first register <= word address < second register.
- R5: Outside-range mode (pair mode 11) hits when the word address is below the first register or at or above the second.
- R6: The reserved code 01 in any qualifier or pair mode field never produces a hit.
- R7: In a range mode the pair reports its hit on the flag of its first compare (`cmp_hit[0]` or `cmp_hit[2]`), the second flag stays 0, and only the first compare's qualifiers apply.
- R8: With auto-toggle set in a range mode, every range hit inverts the pair's range sense from the next cycle on; any write to the control word restores the programmed sense.
- R9: No flag is raised while `fetch_valid` is 0.
- R10: `dbg_event` is 1 exactly in the cycle after a cycle in which any `cmp_hit` bit is 1.
- R11: Reset clears all registers to 0. `cfg_sel` 0 selects the control word and 1..4 select compare registers 1..4. Compare registers read back with bits [1:0] as 0. Reserved control bits read as 0. Other select values ignore writes and read 0.
- R12: Control word bits (31 = most significant): compare 1 privilege [31:30], translation [29:28]; compare 2 privilege [27:26], translation [25:24]; pair 1/2 mode [23:22], auto-toggle [16]; the same layout shifted down by 16 for compares 3/4 (mode [7:6], auto-toggle [0]); bits [21:17] and [5:1] are reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | Fetch beat valid |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_user | input | 1 | Privilege of the fetch, 1 = user |
| fetch_ispace | input | 1 | Instruction translation-space bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1..4 compare |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| cmp_hit | output | 4 | Per-compare hit flags |
| dbg_event | output | 1 | Registered debug event pulse |

## Verification
The assertions assume that reset is held from time zero and that `cfg_we` and `cfg_sel` are never unknown. The auto-toggle check also assumes that the pair's sense can change only on a valid beat or a control write. The bench drives every input on the falling edge. It keeps `fetch_valid` low while it writes configuration, so each valid beat is seen by exactly one rising edge. That makes toggle steps and event timing countable beat by beat.

// File: rtl/fwatch_pkg.sv
package fwatch_pkg;
  localparam int CTRL_W = 32;
  localparam int NUM_PAIRS = 2;
  localparam int NUM_CMP = 2 * NUM_PAIRS;
  localparam int PAIR_STRIDE = CTRL_W / NUM_PAIRS;

  // writable control bits; everything else reads as zero
  localparam logic [CTRL_W-1:0] CTRL_MASK = 32'hFFC1_FFC1;

  localparam logic [1:0] QUAL_ANY  = 2'b00;
  localparam logic [1:0] QUAL_ZERO = 2'b10;
  localparam logic [1:0] QUAL_ONE  = 2'b11;

  localparam logic [1:0] MODE_EXACT = 2'b00;
  localparam logic [1:0] MODE_IN    = 2'b10;
  localparam logic [1:0] MODE_OUT   = 2'b11;

  typedef struct packed {
    logic [1:0] priv;
    logic [1:0] space;
  } cmp_qual_t;

  typedef struct packed {
    cmp_qual_t  qa;
    cmp_qual_t  qb;
    logic [1:0] mode;
    logic       auto_tog;
  } pair_cfg_t;

  function automatic logic qual_pass(input logic [1:0] code, input logic bit_v);
    case (code)
      QUAL_ANY:  return 1'b1;
      QUAL_ZERO: return ~bit_v;
      QUAL_ONE:  return bit_v;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fwatch_regs.sv
module fwatch_regs
  import fwatch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [2:0]                       cfg_sel,
  input  logic [CTRL_W-1:0]                cfg_wdata,
  output logic [CTRL_W-1:0]                cfg_rdata,
  output logic [CTRL_W-1:0]                ctrl_q,
  output logic [NUM_CMP-1:0][ADDR_W-3:0]   cmp_q,
  output logic                             ctrl_wr
);
  localparam int WORD_W = ADDR_W - 2;

  assign ctrl_wr = cfg_we && (cfg_sel == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= cfg_wdata & CTRL_MASK;
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_q[i] <= '0;
      else if (cfg_we && (cfg_sel == 3'(i + 1))) cmp_q[i] <= cfg_wdata[ADDR_W-1:2];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel == 3'd0) cfg_rdata = ctrl_q;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (cfg_sel == 3'(i + 1)) cfg_rdata = CTRL_W'({cmp_q[i], 2'b00});
    end
  end

  localparam int UNUSED_W = WORD_W;
endmodule

// File: rtl/fwatch_pair.sv
module fwatch_pair
  import fwatch_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              user,
  input  logic              ispace,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] reg_a,
  input  logic [WORD_W-1:0] reg_b,
  input  pair_cfg_t         cfg,
  input  logic              clr_tog,
  output logic [1:0]        hit,
  output logic              tog_q
);
  logic qa_ok, qb_ok, in_rng, sense_out, rng_hit, is_range;

  always_comb begin
    qa_ok     = qual_pass(cfg.qa.priv, user) & qual_pass(cfg.qa.space, ispace);
    qb_ok     = qual_pass(cfg.qb.priv, user) & qual_pass(cfg.qb.space, ispace);
    in_rng    = (word >= reg_a) && (word < reg_b);
    sense_out = cfg.mode[0] ^ tog_q;
    rng_hit   = sense_out ? ~in_rng : in_rng;
    is_range  = (cfg.mode == MODE_IN) || (cfg.mode == MODE_OUT);
    hit       = 2'b00;
    case (cfg.mode)
      MODE_EXACT: hit = {valid & qb_ok & (word == reg_b), valid & qa_ok & (word == reg_a)};
      MODE_IN, MODE_OUT: hit = {1'b0, valid & qa_ok & rng_hit};
      default:    hit = 2'b00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else if (clr_tog) tog_q <= 1'b0;
    else if (cfg.auto_tog && is_range && hit[0]) tog_q <= ~tog_q;
  end
endmodule

// File: rtl/fwatch_top.sv
module fwatch_top
  import fwatch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_user,
  input  logic              fetch_ispace,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [3:0]        cmp_hit,
  output logic              dbg_event
);
  localparam int WORD_W = ADDR_W - 2;

  logic [CTRL_W-1:0]              ctrl_q;
  logic [NUM_CMP-1:0][WORD_W-1:0] cmp_q;
  logic                           ctrl_wr;
  logic [NUM_PAIRS-1:0]           tog_q;

  fwatch_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctrl_q(ctrl_q),
    .cmp_q(cmp_q), .ctrl_wr(ctrl_wr)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int TOP = CTRL_W - 1 - p * PAIR_STRIDE;
    pair_cfg_t cfg;
    always_comb begin
      cfg.qa.priv  = ctrl_q[TOP -: 2];
      cfg.qa.space = ctrl_q[TOP-2 -: 2];
      cfg.qb.priv  = ctrl_q[TOP-4 -: 2];
      cfg.qb.space = ctrl_q[TOP-6 -: 2];
      cfg.mode     = ctrl_q[TOP-8 -: 2];
      cfg.auto_tog = ctrl_q[TOP-15];
    end

    fwatch_pair #(.WORD_W(WORD_W)) u_pair (
      .clk(clk), .rst_n(rst_n), .valid(fetch_valid), .user(fetch_user),
      .ispace(fetch_ispace), .word(fetch_addr[ADDR_W-1:2]),
      .reg_a(cmp_q[2*p]), .reg_b(cmp_q[2*p+1]), .cfg(cfg),
      .clr_tog(ctrl_wr), .hit(cmp_hit[2*p +: 2]), .tog_q(tog_q[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_event <= 1'b0;
    else dbg_event <= |cmp_hit;
  end

  logic unused_addr_lo;
  assign unused_addr_lo = ^fetch_addr[1:0];
endmodule

// File: rtl/fwatch_chk.sv
module fwatch_chk
  import fwatch_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_valid,
  input logic        cfg_we,
  input logic [2:0]  cfg_sel,
  input logic [31:0] cfg_rdata,
  input logic [31:0] ctrl,
  input logic [3:0]  cmp_hit,
  input logic        dbg_event,
  input logic [1:0]  tog
);
  logic ctrl_write;
  assign ctrl_write = cfg_we && (cfg_sel == 3'd0);

  assert_no_hit_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (cmp_hit == 4'b0000));

  assert_event_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmp_hit) |=> dbg_event);

  assert_event_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|cmp_hit) |=> !dbg_event);

  assert_range_flag12_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[23] |-> !cmp_hit[1]);

  assert_range_flag34_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[7] |-> !cmp_hit[3]);

  assert_rsv_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[23:22] == 2'b01) |-> (cmp_hit[1:0] == 2'b00));

  assert_tog_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_write |=> (tog == 2'b00));

  assert_tog_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !ctrl_write) |=> $stable(tog));

  assert_rsv_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 3'd0) |-> ((cfg_rdata & ~CTRL_MASK) == 32'd0));
endmodule

bind fwatch_top fwatch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .cfg_we(cfg_we),
  .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata), .ctrl(ctrl_q), .cmp_hit(cmp_hit),
  .dbg_event(dbg_event), .tog(tog_q)
);

// File: tb/tb_fwatch_top.sv
`timescale 1ns/1ps
module tb_fwatch_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_user = 1'b0;
  logic        fetch_ispace = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  cmp_hit;
  logic        dbg_event;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fwatch_top dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_user(fetch_user), .fetch_ispace(fetch_ispace), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cmp_hit(cmp_hit), .dbg_event(dbg_event)
  );

  typedef struct packed {
    logic [31:0] ctrl, r1, r2, r3, r4, addr;
    logic        user, isp;
    logic [3:0]  exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h100, 1'b0, 1'b0, 4'h1}, // R3
    '{32'h0000_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h103, 1'b0, 1'b0, 4'h1}, // R3
    '{32'h0000_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h104, 1'b0, 1'b0, 4'h0}, // R3
    '{32'h8000_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h100, 1'b1, 1'b0, 4'h0}, // R1
    '{32'h8000_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h100, 1'b0, 1'b0, 4'h1}, // R1
    '{32'hC000_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h100, 1'b1, 1'b0, 4'h1}, // R1
    '{32'h3000_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h100, 1'b0, 1'b0, 4'h0}, // R2
    '{32'h2000_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h100, 1'b0, 1'b0, 4'h1}, // R2
    '{32'h4000_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h100, 1'b0, 1'b0, 4'h0}, // R6
    '{32'h0080_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h1FC, 1'b0, 1'b0, 4'h1}, // R4
    '{32'h0080_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h200, 1'b0, 1'b0, 4'h0}, // R4
    '{32'h0080_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h100, 1'b0, 1'b0, 4'h1}, // R4
    '{32'h00C0_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h200, 1'b0, 1'b0, 4'h1}, // R5
    '{32'h00C0_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h1FC, 1'b0, 1'b0, 4'h0}, // R5
    '{32'h0000_0080, 32'h100, 32'h200, 32'h300, 32'h400, 32'h300, 1'b0, 1'b0, 4'h4}, // R12
    '{32'h0000_0040, 32'h100, 32'h200, 32'h300, 32'h400, 32'h300, 1'b0, 1'b0, 4'h0}, // R6
    '{32'h0000_0000, 32'h500, 32'h500, 32'h500, 32'h600, 32'h500, 1'b0, 1'b0, 4'h7}, // R3
    '{32'hC080_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h150, 1'b0, 1'b0, 4'h0}, // R7
    '{32'h0C80_0000, 32'h100, 32'h200, 32'h300, 32'h400, 32'h150, 1'b0, 1'b0, 4'h1}, // R7
    '{32'h0000_0300, 32'h100, 32'h200, 32'h300, 32'h400, 32'h400, 1'b0, 1'b1, 4'h8}  // R12
  };

  function automatic string req_of(input int idx);
    case (idx)
      0, 1, 2, 16: return "R3";
      3, 4, 5:     return "R1";
      6, 7:        return "R2";
      8, 15:       return "R6";
      9, 10, 11:   return "R4";
      12, 13:      return "R5";
      17, 18:      return "R7";
      default:     return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 3'd0;
  endtask

  task automatic rd(input string req, input logic [2:0] sel, input logic [31:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #1 check(req, cfg_rdata, exp);
  endtask

  // one valid beat: hit flags checked in the beat, event checked one cycle later
  task automatic beat(input string req, input logic [31:0] a, input logic u, input logic s,
                      input logic [3:0] exp);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a; fetch_user = u; fetch_ispace = s;
    #1 check(req, 32'(cmp_hit), 32'(exp));
    @(negedge clk);
    fetch_valid = 1'b0;
    check("R10", 32'(dbg_event), 32'(|exp));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R11)
    rd("R11", 3'd0, 32'h0);
    rd("R11", 3'd1, 32'h0);
    rd("R11", 3'd4, 32'h0);
    check("R11", 32'(dbg_event), 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, VECS[i].ctrl);
      wr(3'd1, VECS[i].r1);
      wr(3'd2, VECS[i].r2);
      wr(3'd3, VECS[i].r3);
      wr(3'd4, VECS[i].r4);
      beat(req_of(i), VECS[i].addr, VECS[i].user, VECS[i].isp, VECS[i].exp);
    end

    // readback masking (R11, R12)
    wr(3'd0, 32'hFFFF_FFFF);
    rd("R12", 3'd0, 32'hFFC1_FFC1);
    wr(3'd1, 32'h1234_5677);
    rd("R11", 3'd1, 32'h1234_5674);
    wr(3'd5, 32'hDEAD_BEEF);
    rd("R11", 3'd5, 32'h0);
    rd("R11", 3'd1, 32'h1234_5674);

    // valid gating (R9): exact match address but no valid beat
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h100);
    wr(3'd2, 32'h200);
    @(negedge clk);
    fetch_addr = 32'h100; fetch_valid = 1'b0;
    #1 check("R9", 32'(cmp_hit), 32'h0);
    @(negedge clk);
    check("R9", 32'(dbg_event), 32'h0);

    // auto-toggle (R8): inside range with toggle on pair 1/2
    wr(3'd0, 32'h0081_0000);
    beat("R8", 32'h150, 1'b0, 1'b0, 4'h1);  // inside hit, sense flips
    beat("R8", 32'h150, 1'b0, 1'b0, 4'h0);  // now outside sense
    beat("R8", 32'h250, 1'b0, 1'b0, 4'h1);  // outside hit, flips back
    beat("R8", 32'h250, 1'b0, 1'b0, 4'h0);  // inside sense again
    beat("R8", 32'h150, 1'b0, 1'b0, 4'h1);  // inside hit, sense flips
    wr(3'd0, 32'h0081_0000);                // control write restores sense
    beat("R8", 32'h150, 1'b0, 1'b0, 4'h1);

    // without auto-toggle the sense stays put (R4)
    wr(3'd0, 32'h0080_0000);
    beat("R4", 32'h150, 1'b0, 1'b0, 4'h1);
    beat("R4", 32'h150, 1'b0, 1'b0, 4'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule